// File: doc/BRIEF.md
# ModR/M Effective Address Generator

This block forms the memory effective address of an instruction that addresses its operand through a ModR/M byte. It takes the ModR/M byte, the optional SIB byte, the raw displacement bits, and the base and index register values that the register file has already read. It also takes the address of the instruction that follows and the current processor mode. It produces a 64-bit address one clock later, together with two flags. One flag says whether the operand is in memory at all. The other says whether the address was formed relative to the instruction pointer.

In 64-bit mode, the ModR/M encoding that would otherwise mean "32-bit displacement, no base" is taken as next-instruction address plus the sign-extended 32-bit displacement. The SIB-encoded forms that have no base still count from zero. In the legacy and compatibility modes no form is relative to the instruction pointer, and the result is reduced to its low 32 bits. Segment bases, limit checks, paging and 16-bit addressing are left to other blocks.

Top module: `modrm_ea_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `out_mem`, `out_ip_rel` and `out_ea` are all zero.
- R2: The outputs describe the request presented one clock earlier, and `out_valid` equals the `in_valid` of the previous cycle.
- R3: In 64-bit mode (`mode` = 2), with ModR/M mod = 00 and r/m = 101, `out_ea` = `next_ip` + sign-extended `disp[31:0]` and `out_ip_rel` = 1. `base_val` has no effect.
- R4: In any other mode (`mode` = 0, 1 or 3), the same encoding gives `out_ea` = `disp[31:0]` zero-extended and `out_ip_rel` = 0.
- R5: With mod = 00, r/m = 100 and SIB base field (bits 2:0) = 101, no base is added and the sign-extended 32-bit displacement is used. `out_ip_rel` = 0 in every mode. If the SIB index field (bits 5:3) is also 100, the address is the displacement alone.
- R6: With r/m = 100 and mod ≠ 11, the address is the sum of three terms: `base_val`, `index_val` shifted left by the SIB scale field (bits 7:6), and the displacement. An index field of 100 drops the index term.
- R7: mod = 01 adds `disp[7:0]` sign-extended. mod = 10 adds `disp[31:0]` sign-extended. mod = 00 adds no displacement, except in the forms of R3, R4 and R5. Unused displacement bits have no effect.
- R8: In modes 0, 1 and 3, bits 63:32 of `out_ea` are zero and bits 31:0 are the 64-bit sum taken modulo 2^32.
- R9: With mod = 11 (register operand), `out_mem` = 0, `out_ip_rel` = 0 and `out_ea` = 0. Every other mod value gives `out_mem` = 1.
- R10: `out_ip_rel` is 1 only for the R3 encoding in 64-bit mode.
- R11: A cycle with `in_valid` low leaves `out_ea`, `out_mem` and `out_ip_rel` unchanged, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 2 | 0 legacy, 1 compatibility, 2 64-bit, 3 treated as legacy |
| modrm | input | 8 | ModR/M byte: mod [7:6], reg [5:3], r/m [2:0] |
| sib | input | 8 | SIB byte: scale [7:6], index [5:3], base [2:0] |
| disp | input | 32 | Raw displacement bits; 8-bit form uses [7:0] |
| base_val | input | 64 | Base register value |
| index_val | input | 64 | Index register value |
| next_ip | input | 64 | Address of the following instruction |
| out_valid | output | 1 | Result valid |
| out_ea | output | 64 | Effective address |
| out_mem | output | 1 | Operand is in memory |
| out_ip_rel | output | 1 | Address formed relative to next instruction |

## Verification
The hardest case to reach is the one where two encodings both carry a 32-bit displacement and have no base, but only one of them becomes instruction-pointer relative, and only in one mode. A random choice of bytes would rarely hit that exact pairing of ModR/M and SIB with each mode. The stimulus therefore walks every ModR/M value against a strided set of SIB values under all four mode codes, so both no-base forms appear in every mode. It also draws fresh register, displacement and next-address values so that dropped or wrongly included terms change the sum. Directed vectors then add a negative relative displacement, an 8-bit displacement with junk in its upper bits, and idle cycles whose other inputs change.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

   typedef enum logic [1:0] {
      CPU_LEGACY = 2'd0,
      CPU_COMPAT = 2'd1,
      CPU_LONG   = 2'd2,
      CPU_RSVD   = 2'd3
   } cpu_mode_e;

   typedef enum logic [1:0] {
      DSP_NONE  = 2'd0,
      DSP_SHORT = 2'd1,
      DSP_WIDE  = 2'd2
   } dsp_sel_e;

   typedef struct packed {
      logic       mem;
      logic       use_base;
      logic       use_index;
      logic [1:0] scale;
      dsp_sel_e   dsp;
      logic       ip_rel;
      logic       narrow;
   } ea_ctrl_t;

   localparam logic [1:0] MOD_NODISP = 2'b00;
   localparam logic [1:0] MOD_SHORT  = 2'b01;
   localparam logic [1:0] MOD_WIDE   = 2'b10;
   localparam logic [1:0] MOD_REG    = 2'b11;
   localparam logic [2:0] RM_HAS_SIB = 3'b100;
   localparam logic [2:0] RM_NOBASE  = 3'b101;
   localparam logic [2:0] SIB_NOIDX  = 3'b100;
   localparam logic [2:0] SIB_NOBASE = 3'b101;

endpackage

// File: rtl/eagen_decode.sv
module eagen_decode
   import eagen_pkg::*;
(
   input  cpu_mode_e  mode,
   input  logic [7:0] modrm,
   input  logic [7:0] sib,
   output ea_ctrl_t   ctrl
);

   logic [1:0] mod_f;
   logic [2:0] rm_f;
   logic       long_m;

   assign mod_f  = modrm[7:6];
   assign rm_f   = modrm[2:0];
   assign long_m = (mode == CPU_LONG);

   always_comb begin
      ctrl           = '0;
      ctrl.dsp       = DSP_NONE;
      ctrl.narrow    = !long_m;
      ctrl.scale     = sib[7:6];
      if (mod_f != MOD_REG) begin
         ctrl.mem = 1'b1;
         case (mod_f)
            MOD_SHORT: ctrl.dsp = DSP_SHORT;
            MOD_WIDE:  ctrl.dsp = DSP_WIDE;
            default:   ctrl.dsp = DSP_NONE;
         endcase
         if (rm_f == RM_HAS_SIB) begin
            ctrl.use_index = (sib[5:3] != SIB_NOIDX);
            if (mod_f == MOD_NODISP && sib[2:0] == SIB_NOBASE) begin
               ctrl.use_base = 1'b0;
               ctrl.dsp      = DSP_WIDE;
            end else begin
               ctrl.use_base = 1'b1;
            end
         end else if (mod_f == MOD_NODISP && rm_f == RM_NOBASE) begin
            ctrl.use_base = 1'b0;
            ctrl.dsp      = DSP_WIDE;
            ctrl.ip_rel   = long_m;
         end else begin
            ctrl.use_base = 1'b1;
         end
      end
   end

endmodule

// File: rtl/eagen_sum.sv
module eagen_sum
   import eagen_pkg::*;
#(
   parameter int AW = 64,
   parameter int DW = 32,
   parameter int SW = 8,
   parameter int NW = 32
) (
   input  ea_ctrl_t        ctrl,
   input  logic [DW-1:0]   disp,
   input  logic [AW-1:0]   base_val,
   input  logic [AW-1:0]   index_val,
   input  logic [AW-1:0]   next_ip,
   output logic [AW-1:0]   ea
);

   localparam int WIDE_PAD  = AW - DW;
   localparam int SHORT_PAD = AW - SW;

   logic [AW-1:0] d_short, d_wide, d_sel;
   logic [AW-1:0] base_op, idx_op, full;

   assign d_short = {{SHORT_PAD{disp[SW-1]}}, disp[SW-1:0]};
   assign d_wide  = {{WIDE_PAD{disp[DW-1]}}, disp};

   always_comb begin
      case (ctrl.dsp)
         DSP_SHORT: d_sel = d_short;
         DSP_WIDE:  d_sel = d_wide;
         default:   d_sel = '0;
      endcase
   end

   assign base_op = ctrl.ip_rel   ? next_ip :
                    ctrl.use_base ? base_val : '0;
   assign idx_op  = ctrl.use_index ? (index_val << ctrl.scale) : '0;
   assign full    = base_op + idx_op + d_sel;

   generate
      if (NW < AW) begin : g_narrow
         always_comb begin
            if (!ctrl.mem)       ea = '0;
            else if (ctrl.narrow) ea = {{(AW-NW){1'b0}}, full[NW-1:0]};
            else                 ea = full;
         end
      end else begin : g_full
         assign ea = ctrl.mem ? full : '0;
      end
   endgenerate

endmodule

// File: rtl/eagen_stage.sv
module eagen_stage #(
   parameter int AW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [AW-1:0] ea_d,
   input  logic          mem_d,
   input  logic          ip_rel_d,
   output logic          out_valid,
   output logic [AW-1:0] out_ea,
   output logic          out_mem,
   output logic          out_ip_rel
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_ea     <= '0;
         out_mem    <= 1'b0;
         out_ip_rel <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_ea     <= ea_d;
            out_mem    <= mem_d;
            out_ip_rel <= ip_rel_d;
         end
      end
   end

endmodule

// File: rtl/modrm_ea_gen.sv
module modrm_ea_gen
   import eagen_pkg::*;
#(
   parameter int AW = 64,
   parameter int DW = 32,
   parameter int SW = 8,
   parameter int NW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [1:0]    mode,
   input  logic [7:0]    modrm,
   input  logic [7:0]    sib,
   input  logic [DW-1:0] disp,
   input  logic [AW-1:0] base_val,
   input  logic [AW-1:0] index_val,
   input  logic [AW-1:0] next_ip,
   output logic          out_valid,
   output logic [AW-1:0] out_ea,
   output logic          out_mem,
   output logic          out_ip_rel
);

   generate
      if (DW >= AW) begin : g_bad_dw
         $error("displacement width must be below address width");
      end
      if (SW >= DW || SW < 2) begin : g_bad_sw
         $error("short displacement width must lie in [2, DW)");
      end
      if (NW > AW || NW < 8) begin : g_bad_nw
         $error("narrow width must lie in [8, AW]");
      end
   endgenerate

   cpu_mode_e     mode_e;
   ea_ctrl_t      ctrl;
   logic [AW-1:0] ea_c;

   assign mode_e = cpu_mode_e'(mode);

   eagen_decode u_dec (
      .mode  (mode_e),
      .modrm (modrm),
      .sib   (sib),
      .ctrl  (ctrl)
   );

   eagen_sum #(.AW(AW), .DW(DW), .SW(SW), .NW(NW)) u_sum (
      .ctrl      (ctrl),
      .disp      (disp),
      .base_val  (base_val),
      .index_val (index_val),
      .next_ip   (next_ip),
      .ea        (ea_c)
   );

   eagen_stage #(.AW(AW)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .ea_d       (ea_c),
      .mem_d      (ctrl.mem),
      .ip_rel_d   (ctrl.ip_rel),
      .out_valid  (out_valid),
      .out_ea     (out_ea),
      .out_mem    (out_mem),
      .out_ip_rel (out_ip_rel)
   );

endmodule

// File: rtl/modrm_ea_gen_chk.sv
module modrm_ea_gen_chk #(
   parameter int AW = 64,
   parameter int DW = 32,
   parameter int NW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [1:0]    mode,
   input logic [7:0]    modrm,
   input logic [DW-1:0] disp,
   input logic [AW-1:0] next_ip,
   input logic          out_valid,
   input logic [AW-1:0] out_ea,
   input logic          out_mem,
   input logic          out_ip_rel
);

   logic [AW-1:0] dsx, dzx;
   logic          nodisp_nobase, long_m;

   assign dsx = {{(AW-DW){disp[DW-1]}}, disp};
   assign dzx = {{(AW-DW){1'b0}}, disp};
   assign nodisp_nobase = (modrm[7:6] == 2'b00) && (modrm[2:0] == 3'b101);
   assign long_m = (mode == 2'd2);

   p_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_ea) && $stable(out_mem) && $stable(out_ip_rel)));

   p_regform_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && modrm[7:6] == 2'b11) |=> (!out_mem && !out_ip_rel && out_ea == '0));

   p_iprel_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !long_m) |=> !out_ip_rel);

   p_rel_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && long_m && nodisp_nobase) |=>
         (out_ip_rel && out_ea == $past(next_ip) + $past(dsx)));

   p_abs_disp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !long_m && nodisp_nobase) |=> (!out_ip_rel && out_ea == $past(dzx)));

   generate
      if (NW < AW) begin : g_hi
         p_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !long_m) |=> (out_ea[AW-1:NW] == '0));
      end
   endgenerate

endmodule

bind modrm_ea_gen modrm_ea_gen_chk #(.AW(AW), .DW(DW), .NW(NW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .mode       (mode),
   .modrm      (modrm),
   .disp       (disp),
   .next_ip    (next_ip),
   .out_valid  (out_valid),
   .out_ea     (out_ea),
   .out_mem    (out_mem),
   .out_ip_rel (out_ip_rel)
);

// File: tb/modrm_ea_gen_bench.sv
`timescale 1ns/1ps
module modrm_ea_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  mode = '0;
   logic [7:0]  modrm = '0;
   logic [7:0]  sib = '0;
   logic [31:0] disp = '0;
   logic [63:0] base_val = '0;
   logic [63:0] index_val = '0;
   logic [63:0] next_ip = '0;
   logic        out_valid;
   logic [63:0] out_ea;
   logic        out_mem;
   logic        out_ip_rel;

   int n_chk = 0;
   int n_bad = 0;
   logic [63:0] seed = 64'h0123_4567_89AB_CDEF;

   always #2.5 clk = ~clk;

   modrm_ea_gen u_modrm_ea_gen (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .modrm(modrm), .sib(sib), .disp(disp), .base_val(base_val),
      .index_val(index_val), .next_ip(next_ip), .out_valid(out_valid),
      .out_ea(out_ea), .out_mem(out_mem), .out_ip_rel(out_ip_rel)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
      end
   endtask

   function automatic logic [63:0] next_rand(input logic [63:0] s);
      return s * 64'd6364136223846793005 + 64'd1442695040888963407;
   endfunction

   task automatic model(input logic [1:0] m, input logic [7:0] mr, input logic [7:0] sb,
                        input logic [31:0] d, input logic [63:0] b, input logic [63:0] ix,
                        input logic [63:0] nip, output logic [63:0] ea,
                        output logic rel, output logic mem, output string tag);
      logic [1:0]  md = mr[7:6];
      logic [2:0]  rm = mr[2:0];
      logic        lng = (m == 2'd2);
      logic [63:0] d32 = {{32{d[31]}}, d};
      logic [63:0] dsel;
      logic [63:0] bterm;
      logic [63:0] iterm;
      rel = 1'b0;
      mem = (md != 2'b11);
      dsel = (md == 2'b01) ? {{56{d[7]}}, d[7:0]} : (md == 2'b10) ? d32 : 64'd0;
      if (!mem) begin
         ea = '0; tag = "R9";
      end else if (md == 2'b00 && rm == 3'b101) begin
         if (lng) begin ea = nip + d32; rel = 1'b1; tag = "R3"; end
         else begin ea = d32; tag = "R4"; end
      end else if (rm == 3'b100) begin
         iterm = (sb[5:3] == 3'b100) ? 64'd0 : (ix << sb[7:6]);
         if (md == 2'b00 && sb[2:0] == 3'b101) begin
            bterm = '0; dsel = d32; tag = "R5";
         end else begin
            bterm = b; tag = "R6";
         end
         ea = bterm + iterm + dsel;
      end else begin
         ea = b + dsel; tag = "R7";
      end
      if (!lng) ea[63:32] = '0;
   endtask

   // Drive one request after a falling edge, then check at the next falling edge.
   task automatic run_vec(input logic [1:0] m, input logic [7:0] mr, input logic [7:0] sb,
                          input logic [31:0] d, input logic [63:0] b, input logic [63:0] ix,
                          input logic [63:0] nip);
      logic [63:0] e_ea;
      logic        e_rel, e_mem;
      string       tag;
      in_valid = 1'b1; mode = m; modrm = mr; sib = sb; disp = d;
      base_val = b; index_val = ix; next_ip = nip;
      model(m, mr, sb, d, b, ix, nip, e_ea, e_rel, e_mem, tag);
      @(negedge clk);
      chk("R2", "out_valid", {63'd0, out_valid}, 64'd1);
      chk(tag, "out_ea", out_ea, e_ea);
      chk("R9", "out_mem", {63'd0, out_mem}, {63'd0, e_mem});
      chk("R10", "out_ip_rel", {63'd0, out_ip_rel}, {63'd0, e_rel});
      if (m != 2'd2) chk("R8", "upper half", {32'd0, out_ea[63:32]}, 64'd0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [63:0] keep_ea;
      logic        keep_rel, keep_mem;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "out_valid in reset", {63'd0, out_valid}, 64'd0);
      chk("R1", "out_ea in reset", out_ea, 64'd0);
      chk("R1", "out_ip_rel in reset", {63'd0, out_ip_rel}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "out_mem after reset", {63'd0, out_mem}, 64'd0);
      chk("R2", "out_valid idle", {63'd0, out_valid}, 64'd0);

      // R3: negative relative displacement crossing a 4 GB boundary
      run_vec(2'd2, 8'h05, 8'h00, 32'hFFFF_FFF0, 64'hDEAD_0000_0000_0000,
              64'h0, 64'h0000_0001_0000_0010);
      chk("R3", "negative rel", out_ea, 64'h0000_0001_0000_0000);
      // R7: short displacement, junk in upper disp bits ignored
      run_vec(2'd2, 8'h40, 8'h00, 32'h1234_5680, 64'h1000, 64'h0, 64'h0);
      chk("R7", "disp8 negative", out_ea, 64'h0F80);
      // R5: SIB no-base, no-index form stays absolute in 64-bit mode
      run_vec(2'd2, 8'h04, 8'h25, 32'h8000_0000, 64'h5555, 64'h7777, 64'h9999);
      chk("R5", "sib abs", out_ea, 64'hFFFF_FFFF_8000_0000);
      chk("R5", "sib abs rel flag", {63'd0, out_ip_rel}, 64'd0);
      // R4: compatibility mode, same encoding absolute
      run_vec(2'd1, 8'h05, 8'h00, 32'h8000_0004, 64'h5555, 64'h0, 64'h1_0000_0000);
      chk("R4", "abs disp", out_ea, 64'h0000_0000_8000_0004);

      // R11: idle cycle with changed inputs leaves outputs alone
      keep_ea = out_ea; keep_rel = out_ip_rel; keep_mem = out_mem;
      in_valid = 1'b0; mode = 2'd2; modrm = 8'h05; next_ip = 64'h4444_0000;
      disp = 32'h10; base_val = 64'hABCD;
      @(negedge clk);
      chk("R11", "ea held", out_ea, keep_ea);
      chk("R11", "ip_rel held", {63'd0, out_ip_rel}, {63'd0, keep_rel});
      chk("R11", "mem held", {63'd0, out_mem}, {63'd0, keep_mem});
      chk("R2", "valid dropped", {63'd0, out_valid}, 64'd0);

      // Sweep: every mode code x every ModR/M x strided SIB
      for (int m = 0; m < 4; m++) begin
         for (int mr = 0; mr < 256; mr++) begin
            for (int sb = 0; sb < 256; sb += 7) begin
               logic [63:0] r1, r2, r3;
               seed = next_rand(seed); r1 = seed;
               seed = next_rand(seed); r2 = seed;
               seed = next_rand(seed); r3 = seed;
               run_vec(m[1:0], mr[7:0], sb[7:0], r1[31:0], r2, r3, {r1[63:32], r2[63:32]});
            end
            // SIB no-base with index present, mod 00
            seed = next_rand(seed);
            run_vec(m[1:0], mr[7:0], 8'hC5, seed[31:0], seed, ~seed, {seed[15:0], seed[63:16]});
         end
      end

      in_valid = 1'b0;
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule